// File: doc/BRIEF.md
# Byte-Wide Full-Duplex Serial Peripheral Controller

This block is a serial peripheral interface controller for one byte at a time. A processor drives it through a small register bus with three addressable registers: control, status and data. When the control register selects master operation, a write to the data register starts a transfer. The controller makes the serial clock from the module clock with one of four divide ratios. It sends the byte on its data output and, in the same transfer, fills the shift register from its data input. When master operation is not selected, the controller is a slave. The serial clock and an active-low select come from outside, and the controller answers on its slave data output.

A one-byte transmit buffer sits in front of the shift register, and a holding register sits behind it. The buffer moves into the shift register as soon as the shifter can take it, so a master with a byte waiting runs the next byte with no gap. A finished byte goes to the holding register and raises a receive-full flag. If a byte finishes while that flag is still set, an overflow flag is raised and the held byte is kept. Both flags clear only when software reads status and then reads data.

The serial format is fixed. The most significant bit goes first and the clock idles low. Output bits change after a falling clock edge, and input bits are taken on a rising edge.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x02 (transmit buffer empty, nothing received, no overflow), and `sck_o` and `mosi_o` are low.
- R2: The bus has three registers. Address 0 is control: bit 0 is master select and bits 2:1 are the rate code, and it reads back as written. Address 1 is status: bit 0 is receive-full, bit 1 is transmit-empty, bit 2 is overflow. Address 2 is data: a write fills the transmit buffer and a read returns the received byte.
- R3: In master mode with the shifter idle, a data write moves the byte into the shifter on the next clock edge. Transmit-empty reads 0 right after the write edge and 1 one cycle later.
- R4: Rate codes 0, 1, 2 and 3 divide the module clock by 2, 8, 32 and 128. Receive-full is set exactly 1 + 8·divide cycles after the clock edge that took the data write.
- R5: Master transfers send MSB first with the clock idling low. Each output bit is stable while the clock is high. The byte read back is the 8 bits that were on `miso_i` at the 8 rising clock edges.
- R6: If a master has a byte in the transmit buffer when a byte finishes, the next byte starts at once. It completes exactly 8·divide cycles after the previous one.
- R7: A data read clears receive-full only if a status read that saw a flag set came before it. A data read without that status read leaves the flag set.
- R8: If a byte completes while receive-full is set, overflow is set and the earlier byte stays in the data register. The same status-then-data read sequence clears overflow.
- R9: In slave mode, with `ss_n_i` low, the byte sampled from `mosi_i` on the rising edges of `sck_i` goes to the data register. Receive-full is set on the third module clock edge after the eighth falling edge of `sck_i`.
- R10: In slave mode, a buffered byte loads into the shifter while `ss_n_i` is high. It is then sent MSB first on `miso_o`, one bit per falling edge of `sck_i`.
- R11: In slave mode, raising `ss_n_i` during a byte throws away the partial bits. The next byte is framed from its first bit.
- R12: In slave mode a data write starts no transfer: `sck_o` stays low and receive-full stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| sck_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master serial data out |
| miso_i | input | 1 | Master serial data in |
| sck_i | input | 1 | Slave serial clock in |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Slave serial data in |
| miso_o | output | 1 | Slave serial data out |

## Verification
In master mode the shifter load is due one cycle after the write edge. The receive-full flag is due 1 + 8·divide cycles after that edge, and a gapless second byte finishes 8·divide cycles after the first. The bench counts cycles from the write and compares the count against these exact values, not against a window. In slave mode the bench moves the serial inputs on falling module-clock edges. It reads status on the second falling edge after the final serial clock fall, where the flag must still be clear, and again on the third, where it must be set. Every read and peek happens half a cycle away from the active edge.

// File: rtl/spi_xcvr_pkg.sv
// Shared constants and types for the serial controller.
// Assumes a two-bit register address space with three used slots.
package spi_xcvr_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2
    } reg_sel_e;

    // bit positions software depends on
    localparam int CTRL_MASTER_BIT = 0;
    localparam int CTRL_RATE_LSB   = 1;
    localparam int STAT_RXF_BIT    = 0;
    localparam int STAT_TXE_BIT    = 1;
    localparam int STAT_OVF_BIT    = 2;

endpackage

// File: rtl/spi_sync.sv
// Two-flop synchronizer bank for asynchronous serial inputs.
// Assumes inputs change far slower than the module clock; each bit has its own reset level.
module spi_sync #(
    parameter int              W       = 3,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic stage1, stage2;
            // two-stage capture of one asynchronous bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage1 <= RST_VAL[i];
                    stage2 <= RST_VAL[i];
                end else begin
                    stage1 <= d[i];
                    stage2 <= stage1;
                end
            end
            assign q[i] = stage2;
        end
    endgenerate

endmodule

// File: rtl/spi_rate_gen.sv
// Half-period tick source for the master serial clock.
// Rate code n gives a half period of 2^(STEP_LOG2*n) module clocks; counting restarts whenever run is low.
module spi_rate_gen #(
    parameter int RATE_W    = 2,
    parameter int STEP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    localparam int NUM_RATES = 1 << RATE_W;
    localparam int MAX_HALF  = 1 << (STEP_LOG2 * (NUM_RATES - 1));
    localparam int CNT_W     = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    // terminal count for the selected rate
    always_comb begin
        half_m1 = CNT_W'((32'd1 << (STEP_LOG2 * int'(rate))) - 32'd1);
    end

    assign tick = run && (cnt == half_m1);

    // half-period counter
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_shifter.sv
// Shared shift engine for master and slave operation.
// Master: runs on rate ticks and drives the clock; slave: follows synchronized clock/select edges.
// Samples on rising clock, shifts on falling clock, MSB first. Consumes the transmit buffer when free.
module spi_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master,
    input  logic          tick,
    input  logic          buf_full,
    input  logic [DW-1:0] buf_data,
    output logic          consume,
    output logic          busy,
    output logic          sck_o,
    output logic          mosi_o,
    input  logic          miso_i,
    input  logic          s_sck,
    input  logic          s_ss_n,
    input  logic          s_mosi,
    output logic          miso_o,
    output logic          done,
    output logic [DW-1:0] rx_byte
);

    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    logic [DW-1:0] shreg;
    logic [BW-1:0] bitcnt;
    logic          samp;
    logic          busy_q;
    logic          sck_q;
    logic          s_sck_d;
    logic          rise_m, fall_m, s_rise, s_fall, rise, fall, in_bit, last;

    // edge decode for both modes
    always_comb begin
        rise_m  = master && busy_q && tick && !sck_q;
        fall_m  = master && busy_q && tick && sck_q;
        s_rise  = !master && !s_ss_n && s_sck && !s_sck_d;
        s_fall  = !master && !s_ss_n && !s_sck && s_sck_d;
        rise    = rise_m || s_rise;
        fall    = fall_m || s_fall;
        in_bit  = master ? miso_i : s_mosi;
        last    = (bitcnt == BW'(DW - 1));
        done    = fall && last;
        rx_byte = {shreg[DW-2:0], samp};
        consume = buf_full && (master ? (!busy_q || (fall_m && last)) : s_ss_n);
    end

    // delayed slave clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) s_sck_d <= 1'b0;
        else        s_sck_d <= s_sck;
    end

    // shift register load and shift
    always_ff @(posedge clk) begin
        if (!rst_n)       shreg <= '0;
        else if (consume) shreg <= buf_data;
        else if (fall)    shreg <= rx_byte;
    end

    // input bit capture on rising clock
    always_ff @(posedge clk) begin
        if (!rst_n)    samp <= 1'b0;
        else if (rise) samp <= in_bit;
    end

    // bit counter, cleared when idle or deselected
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0;
        end else if (master ? !busy_q : s_ss_n) begin
            bitcnt <= '0;
        end else if (fall) begin
            bitcnt <= last ? '0 : bitcnt + 1'b1;
        end
    end

    // master activity flag
    always_ff @(posedge clk) begin
        if (!rst_n || !master)              busy_q <= 1'b0;
        else if (!busy_q && buf_full)       busy_q <= 1'b1;
        else if (fall_m && last && !buf_full) busy_q <= 1'b0;
    end

    // master serial clock
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_q || !master) sck_q <= 1'b0;
        else if (tick)                    sck_q <= !sck_q;
    end

    assign busy   = busy_q;
    assign sck_o  = sck_q;
    assign mosi_o = (master && busy_q) ? shreg[DW-1] : 1'b0;
    assign miso_o = master ? 1'b0 : shreg[DW-1];

    // R5
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sck_q);

    // R11
    slave_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && s_ss_n) |=> (bitcnt == '0));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/spi_regs.sv
// Register bank: control, status flags, transmit buffer and receive holding register.
// Assumes reads have no side effects except the status-then-data clear sequence.
module spi_regs
    import spi_xcvr_pkg::*;
#(
    parameter int DW     = 8,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              master,
    output logic [RATE_W-1:0] rate,
    output logic              buf_full,
    output logic [DW-1:0]     buf_data,
    input  logic              consume,
    input  logic              done,
    input  logic [DW-1:0]     rx_byte
);

    logic          wr_ctrl, wr_data, rd_stat, rd_data, clr;
    logic          rx_full, ovf, armed;
    logic [DW-1:0] rx_data;

    // bus access decode
    always_comb begin
        wr_ctrl = bus_en && bus_wr  && (bus_addr == REG_CTRL);
        wr_data = bus_en && bus_wr  && (bus_addr == REG_DATA);
        rd_stat = bus_en && !bus_wr && (bus_addr == REG_STAT);
        rd_data = bus_en && !bus_wr && (bus_addr == REG_DATA);
        clr     = rd_data && armed;
    end

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master <= 1'b0;
            rate   <= '0;
        end else if (wr_ctrl) begin
            master <= bus_wdata[CTRL_MASTER_BIT];
            rate   <= bus_wdata[CTRL_RATE_LSB +: RATE_W];
        end
    end

    // transmit buffer: a write fills it, the shifter drains it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            buf_data <= '0;
        end else if (wr_data) begin
            buf_full <= 1'b1;
            buf_data <= bus_wdata;
        end else if (consume) begin
            buf_full <= 1'b0;
        end
    end

    // first half of the clear sequence
    always_ff @(posedge clk) begin
        if (!rst_n || rd_data)            armed <= 1'b0;
        else if (rd_stat && (rx_full || ovf)) armed <= 1'b1;
    end

    // receive holding register, receive-full and overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            ovf     <= 1'b0;
            rx_data <= '0;
        end else begin
            if (clr) begin
                rx_full <= 1'b0;
                ovf     <= 1'b0;
            end
            if (done) begin
                if (rx_full && !clr) begin
                    ovf <= 1'b1;
                end else begin
                    rx_data <= rx_byte;
                    rx_full <= 1'b1;
                end
            end
        end
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: begin
                bus_rdata[CTRL_MASTER_BIT]              = master;
                bus_rdata[CTRL_RATE_LSB +: RATE_W]      = rate;
            end
            REG_STAT: begin
                bus_rdata[STAT_RXF_BIT] = rx_full;
                bus_rdata[STAT_TXE_BIT] = !buf_full;
                bus_rdata[STAT_OVF_BIT] = ovf;
            end
            REG_DATA: bus_rdata = rx_data;
            default:  bus_rdata = '0;
        endcase
    end

    // R7
    rxf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(rd_data && armed));

    // R8
    ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $stable(rx_data));

    // R3
    txe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_full) |-> $past(consume));

endmodule

// File: rtl/spi_xcvr.sv
// Top level of the serial peripheral controller.
// Joins the register bank, rate generator, input synchronizers and shift engine.
// Assumes the slave serial clock is at least eight times slower than clk.
module spi_xcvr
    import spi_xcvr_pkg::*;
#(
    parameter int DW        = 8,
    parameter int RATE_W    = 2,
    parameter int STEP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o
);

    logic              master, buf_full, consume, busy, tick, done;
    logic [RATE_W-1:0] rate;
    logic [DW-1:0]     buf_data, rx_byte;
    logic [2:0]        sync_q;

    spi_regs #(.DW(DW), .RATE_W(RATE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .master(master), .rate(rate),
        .buf_full(buf_full), .buf_data(buf_data), .consume(consume),
        .done(done), .rx_byte(rx_byte)
    );

    spi_rate_gen #(.RATE_W(RATE_W), .STEP_LOG2(STEP_LOG2)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(busy && master), .rate(rate), .tick(tick)
    );

    // order: {mosi, ss_n, sck}; select idles high
    spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({mosi_i, ss_n_i, sck_i}), .q(sync_q)
    );

    spi_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .master(master), .tick(tick),
        .buf_full(buf_full), .buf_data(buf_data), .consume(consume), .busy(busy),
        .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
        .s_sck(sync_q[0]), .s_ss_n(sync_q[1]), .s_mosi(sync_q[2]),
        .miso_o(miso_o), .done(done), .rx_byte(rx_byte)
    );

endmodule

// File: tb/spi_xcvr_test.sv
// Self-checking bench: directed corner cases plus seeded random bytes and rates.
module spi_xcvr_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic       sck_o, mosi_o, miso_i, miso_o;
    logic       sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;

    int checks = 0, errors = 0;
    int cyc = 0;
    bit finished = 0;

    // bench model of an external slave for master tests
    logic [7:0] mrx [4];
    logic [7:0] cap [4];
    int mcnt = 0, mcap = 0;

    always #4 clk = ~clk;

    spi_xcvr uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
        .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_o(miso_o)
    );

    assign miso_i = mrx[(mcnt / 8) % 4][7 - (mcnt % 8)];

    initial forever @(posedge clk) cyc++;
    initial forever @(negedge sck_o) mcnt++;
    initial forever begin
        @(posedge sck_o);
        cap[(mcap / 8) % 4][7 - (mcap % 8)] = mosi_o;
        mcap++;
    end

    function automatic int exp_div(input int r);
        return 2 << (2 * r);
    endfunction

    function automatic int exp_lat(input int r);
        return 1 + 8 * exp_div(r);
    endfunction

    function automatic logic [7:0] exp_stat(input bit rxf, input bit txe, input bit ovf);
        return {5'b0, ovf, txe, rxf};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic clear_rx(output logic [7:0] d);
        logic [7:0] st;
        bus_read(2'd1, st);
        bus_read(2'd2, d);
    endtask

    // master transfer at a given rate, checking load, latency, wire data and read-back
    task automatic master_xfer(input int r, input logic [7:0] tx, input logic [7:0] rx);
        logic [7:0] st, d;
        int c;
        bus_write(2'd0, {5'b0, r[1:0], 1'b1});
        mrx[0] = rx; mcnt = 0; mcap = 0;
        bus_write(2'd2, tx);
        c = 0;
        peek(2'd1, st);
        chk("R3 txe after write", st[1], 1'b0);
        @(negedge clk); c = 1;
        peek(2'd1, st);
        chk("R3 txe after load", st[1], 1'b1);
        while (!st[0] && c < 3000) begin
            @(negedge clk); c++;
            peek(2'd1, st);
        end
        chk("R4 completion cycles", c, exp_lat(r));
        chk("R5 mosi byte", cap[0], tx);
        bus_read(2'd1, st);
        chk("R2 status full", st, exp_stat(1, 1, 0));
        bus_read(2'd2, d);
        chk("R5 received byte", d, rx);
        peek(2'd1, st);
        chk("R7 cleared by sequence", st, exp_stat(0, 1, 0));
    endtask

    // slave byte driven from the bench; reports miso bits and flag timing
    task automatic slave_byte(input logic [7:0] mo, input int nbits, output logic [7:0] got,
                              output logic rxf_early, output logic rxf_due);
        logic [7:0] st;
        got = 8'h00; rxf_early = 1'b0; rxf_due = 1'b0;
        @(negedge clk) ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi_i = mo[7 - i];
            repeat (8) @(negedge clk);
            got[7 - i] = miso_o;
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
            if (i == 7) begin
                repeat (2) @(negedge clk);
                peek(2'd1, st); rxf_early = st[0];
                @(negedge clk);
                peek(2'd1, st); rxf_due = st[0];
            end
        end
        repeat (8) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] st, d, a, b, got, tx;
        logic e, f;
        int t1, t2, highs;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4; i++) begin mrx[i] = 8'h00; cap[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(2'd0, st); chk("R1 control reset", st, 8'h00);
        peek(2'd1, st); chk("R1 status reset", st, exp_stat(0, 1, 0));
        chk("R1 sck low", sck_o, 1'b0);
        chk("R1 mosi low", mosi_o, 1'b0);

        // R2 control read-back
        bus_write(2'd0, 8'h05);
        peek(2'd0, st); chk("R2 control readback", st, 8'h05);

        // R4 R5 directed patterns at every rate
        master_xfer(0, 8'h80, 8'h01);
        master_xfer(1, 8'hFF, 8'h00);
        master_xfer(2, 8'h00, 8'hFF);
        master_xfer(3, 8'hA5, 8'h3C);
        // random bytes and rates
        for (int k = 0; k < 6; k++) begin
            master_xfer(int'($urandom % 3), 8'($urandom), 8'($urandom));
        end

        // R6 gapless back-to-back at divide 8
        a = 8'($urandom); b = 8'($urandom);
        bus_write(2'd0, 8'h03);
        mrx[0] = 8'h5A; mrx[1] = 8'hC3; mcnt = 0; mcap = 0;
        bus_write(2'd2, a);
        @(negedge clk);
        bus_write(2'd2, b);
        peek(2'd1, st);
        while (!st[0]) begin @(negedge clk); peek(2'd1, st); end
        t1 = cyc;
        clear_rx(d);
        chk("R6 first byte", d, 8'h5A);
        peek(2'd1, st);
        while (!st[0]) begin @(negedge clk); peek(2'd1, st); end
        t2 = cyc;
        chk("R6 gapless spacing", t2 - t1, 8 * exp_div(1));
        clear_rx(d);
        chk("R6 second byte", d, 8'hC3);
        chk("R6 second mosi", cap[1], b);
        chk("R6 first mosi", cap[0], a);

        // R7 data read without status read keeps the flag; R8 overflow
        bus_write(2'd0, 8'h01);
        mrx[0] = 8'h66; mcnt = 0; mcap = 0;
        bus_write(2'd2, 8'h11);
        repeat (40) @(negedge clk);
        bus_read(2'd2, d);
        peek(2'd1, st);
        chk("R7 data read alone keeps flag", st, exp_stat(1, 1, 0));
        mrx[0] = 8'h99; mcnt = 0;
        bus_write(2'd2, 8'h22);
        repeat (40) @(negedge clk);
        peek(2'd1, st);
        chk("R8 overflow set", st, exp_stat(1, 1, 1));
        clear_rx(d);
        chk("R8 earlier byte kept", d, 8'h66);
        peek(2'd1, st);
        chk("R8 overflow cleared", st, exp_stat(0, 1, 0));

        // R12 slave mode write starts nothing
        bus_write(2'd0, 8'h00);
        tx = 8'($urandom);
        bus_write(2'd2, tx);
        highs = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (sck_o) highs++;
        end
        chk("R12 no master clock in slave mode", highs, 0);
        peek(2'd1, st);
        chk("R12 no receive in slave mode", st[0], 1'b0);

        // R9 R10 slave bytes
        for (int k = 0; k < 4; k++) begin
            a = (k == 0) ? 8'h81 : 8'($urandom);
            slave_byte(a, 8, got, e, f);
            chk("R10 slave miso byte", got, tx);
            chk("R9 flag not early", e, 1'b0);
            chk("R9 flag on third edge", f, 1'b1);
            clear_rx(d);
            chk("R9 slave received byte", d, a);
            tx = 8'($urandom);
            bus_write(2'd2, tx);
        end

        // R11 partial byte discarded
        slave_byte(8'hF0, 4, got, e, f);
        tx = 8'h4D;
        bus_write(2'd2, tx);
        slave_byte(8'h2B, 8, got, e, f);
        clear_rx(d);
        chk("R11 byte after abort", d, 8'h2B);
        chk("R11 miso after abort", got, tx);

        // R8 slave overflow
        slave_byte(8'h17, 8, got, e, f);
        slave_byte(8'hE8, 8, got, e, f);
        peek(2'd1, st);
        chk("R8 slave overflow set", st[2], 1'b1);
        clear_rx(d);
        chk("R8 slave keeps first", d, 8'h17);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule